// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes that pace a raster display. A line is made of four segments (active pixels, front porch, sync pulse, back porch), and a frame is made of the same four segments counted in lines. Every segment length is held in a register as its length minus one. A programmable integer divider turns the system clock into a pixel-rate enable, so one timing core can drive panels of different pixel rates.

Software programs the block through a small synchronous write port with a combinational read port. It sets the eight segment lengths, the divisor, the sync polarities and the interrupt controls, then sets the run bit. A frame event can be taken either where vertical sync begins or where the first active line begins. It latches a sticky status bit that is cleared by writing one, and the status drives an interrupt output through a global enable. The current line index can be read back, and a line-match output flags when that index equals a programmed threshold. A soft-reset bit stops the raster and clears the status without losing the configuration.

Each axis is a four-state machine: ACTIVE goes to FRONT, FRONT to SYNC, SYNC to BACK, and BACK back to ACTIVE. Each transition is taken when the segment counter reaches its programmed limit on an advance. The horizontal machine advances on every pixel enable. The vertical machine advances when the horizontal machine leaves BACK. When the block is not running, both machines are forced to ACTIVE with a zero count.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads zero, de, hsync, vsync, frame_irq and line_match are low, and the divisor is one.
- R2: Registers 1, 2, 3 and 4 hold the active, front porch, sync and back porch widths of a line, each as pixel count minus one (bits CW-1:0). A line runs through those segments in that order, and hsync is asserted only during the sync segment.
- R3: Registers 5, 6, 7 and 8 hold the same four lengths for a frame, counted in lines. The frame state advances only when a line ends, and vsync is asserted only during the vertical sync segment.
- R4: Writing a requested divisor N to register 9 stores N-1 (read back on bits 7:0). N=0 is taken as 1, and N above 255 is clamped to 255, so 254 is stored. One pixel then lasts N system clocks.
- R5: de is high only when both axes are in their active segment and the run bit (register 0 bit 0) is set. Register 0 bits 2 and 3 invert hsync and vsync respectively; the default sync polarity is active-high.
- R6: Register 10 bit 1 enables the frame event and bit 2 picks where it fires: at 0, on the pixel where vertical sync begins; at 1, where the first active line begins. An enabled event sets the status bit, register 11 bit 0.
- R7: frame_irq equals the status bit ANDed with the global enable, register 10 bit 0. With the global enable clear, the status still latches but frame_irq stays low.
- R8: Writing 1 to register 11 bit 0 clears the status. If an enabled event occurs in the same cycle, the set wins.
- R9: Register 13 reads the current line index, where the first active line is 0. line_match is high while running and that index equals register 12.
- R10: Writing register 0 with bit 1 set clears the run bit and the status. The polarity bits, segment lengths, divisor and enables keep their values.
- R11: While the run bit is clear, both counters are held at the start of the first active line, the line index reads 0, de is low and each sync output sits at its inactive level. Setting run again starts from the first active pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register index for read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| hsync | output | 1 | Horizontal sync, polarity per register 0 bit 2 |
| vsync | output | 1 | Vertical sync, polarity per register 0 bit 3 |
| de | output | 1 | Data enable, high on active pixels |
| frame_irq | output | 1 | Frame interrupt, status AND global enable |
| line_match | output | 1 | Current line equals the threshold |

## Verification
The bench builds the block with its default parameters (AW=4, DW=16, CW=12). With a 16-bit data port, a divisor request of 300 can be written, which exercises the clamp as well as the zero-divisor case. The raster is programmed with segment lengths of one to eight pixels and lines, including zero-valued fields, so a 15-pixel by 8-line frame completes in about a hundred cycles. Many frames therefore run under both event selections, both polarities and divisors of one and three. Soft reset is applied mid-frame and the raster is then restarted from idle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    localparam int unsigned SEG_N = 4;
    localparam int unsigned DIV_W = 8;

    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_H_BASE = 1;
    localparam int unsigned A_V_BASE = 5;
    localparam int unsigned A_DIV    = 9;
    localparam int unsigned A_IRQEN  = 10;
    localparam int unsigned A_IRQST  = 11;
    localparam int unsigned A_THR    = 12;
    localparam int unsigned A_LINE   = 13;

    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_SWRST = 1;
    localparam int unsigned B_HINV  = 2;
    localparam int unsigned B_VINV  = 3;

endpackage

// File: rtl/rtg_pixdiv.sv
module rtg_pixdiv #(
    parameter int DW_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DW_DIV-1:0] div_m1,
    output logic              tick
);
    logic [DW_DIV-1:0] cnt;

    assign tick = run && (cnt >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && div_m1 != '0) |=> (!tick || $changed(div_m1))); // R4

endmodule

// File: rtl/rtg_seg.sv
module rtg_seg
    import rtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      adv,
    input  logic [SEG_N-1:0][CW-1:0]  lim,
    output seg_e                      state,
    output logic                      last,
    output logic                      wrap
);
    logic [CW-1:0] cnt;
    seg_e          nxt;

    always_comb begin
        last = (cnt >= lim[state]);
    end

    always_comb begin
        nxt = state;
        if (adv && last) begin
            unique case (state)
                SEG_ACTIVE: nxt = SEG_FRONT;
                SEG_FRONT:  nxt = SEG_SYNC;
                SEG_SYNC:   nxt = SEG_BACK;
                SEG_BACK:   nxt = SEG_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEG_ACTIVE;
        end else if (clr) begin
            state <= SEG_ACTIVE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assign wrap = adv && last && (state == SEG_BACK);

    AST_SEG_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (adv && last && !clr) |=> (cnt == '0)); // R2

endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     frame_evt,
    input  logic [CW-1:0]            line_no,
    output logic [DW-1:0]            rdata,
    output logic                     run,
    output logic                     hs_inv,
    output logic                     vs_inv,
    output logic [SEG_N-1:0][CW-1:0] h_lim,
    output logic [SEG_N-1:0][CW-1:0] v_lim,
    output logic [DIV_W-1:0]         div_m1,
    output logic                     glb_en,
    output logic                     frm_en,
    output logic                     evt_sel,
    output logic                     stat,
    output logic [CW-1:0]            thr
);
    localparam int DIV_MAX = (1 << DIV_W) - 1;

    logic hit_ctrl;
    logic swrst_wr;
    logic clr_wr;

    function automatic logic [DIV_W-1:0] to_m1(input logic [DW-1:0] req);
        if (req == '0) begin
            return '0;
        end
        if (req > DW'(DIV_MAX)) begin
            return DIV_W'(DIV_MAX - 1);
        end
        return DIV_W'(req - 1'b1);
    endfunction

    assign hit_ctrl = wr && (addr == AW'(A_CTRL));
    assign swrst_wr = hit_ctrl && wdata[B_SWRST];
    assign clr_wr   = wr && (addr == AW'(A_IRQST)) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            hs_inv <= 1'b0;
            vs_inv <= 1'b0;
        end else if (swrst_wr) begin
            run <= 1'b0;
        end else if (hit_ctrl) begin
            run    <= wdata[B_RUN];
            hs_inv <= wdata[B_HINV];
            vs_inv <= wdata[B_VINV];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_lim <= '0;
            v_lim <= '0;
        end else if (wr) begin
            for (int i = 0; i < SEG_N; i++) begin
                if (addr == AW'(A_H_BASE + i)) h_lim[i] <= wdata[CW-1:0];
                if (addr == AW'(A_V_BASE + i)) v_lim[i] <= wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_m1  <= '0;
            glb_en  <= 1'b0;
            frm_en  <= 1'b0;
            evt_sel <= 1'b0;
            thr     <= '0;
        end else if (wr) begin
            if (addr == AW'(A_DIV)) div_m1 <= to_m1(wdata);
            if (addr == AW'(A_IRQEN)) begin
                glb_en  <= wdata[0];
                frm_en  <= wdata[1];
                evt_sel <= wdata[2];
            end
            if (addr == AW'(A_THR)) thr <= wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else if (swrst_wr) begin
            stat <= 1'b0;
        end else if (frame_evt && frm_en) begin
            stat <= 1'b1;
        end else if (clr_wr) begin
            stat <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_CTRL: begin
                rdata[B_RUN]  = run;
                rdata[B_HINV] = hs_inv;
                rdata[B_VINV] = vs_inv;
            end
            A_DIV:   rdata[DIV_W-1:0] = div_m1;
            A_IRQEN: rdata[2:0] = {evt_sel, frm_en, glb_en};
            A_IRQST: rdata[0] = stat;
            A_THR:   rdata[CW-1:0] = thr;
            A_LINE:  rdata[CW-1:0] = line_no;
            default: begin
                for (int i = 0; i < SEG_N; i++) begin
                    if (int'(addr) == A_H_BASE + i) rdata[CW-1:0] = h_lim[i];
                    if (int'(addr) == A_V_BASE + i) rdata[CW-1:0] = v_lim[i];
                end
            end
        endcase
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) div_m1 != DIV_W'(DIV_MAX)); // R4
    AST_STAT_SETS: assert property (@(posedge clk) disable iff (!rst_n) (frame_evt && frm_en && !swrst_wr) |=> stat); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !(frame_evt && frm_en)) |=> !stat); // R8
    AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) swrst_wr |=> (!run && !stat)); // R10

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          frame_irq,
    output logic          line_match
);
    logic                     run, hs_inv, vs_inv;
    logic [SEG_N-1:0][CW-1:0] h_lim, v_lim;
    logic [DIV_W-1:0]         div_m1;
    logic                     glb_en, frm_en, evt_sel, stat;
    logic [CW-1:0]            thr;
    logic [CW-1:0]            line_no;
    logic                     tick;
    logic                     h_adv, v_adv;
    seg_e                     h_st, v_st;
    logic                     h_last, v_last, h_wrap, v_wrap;
    logic                     frame_evt;
    logic                     v_in_sync;

    rtg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .frame_evt(frame_evt), .line_no(line_no), .rdata(reg_rdata),
        .run(run), .hs_inv(hs_inv), .vs_inv(vs_inv), .h_lim(h_lim), .v_lim(v_lim),
        .div_m1(div_m1), .glb_en(glb_en), .frm_en(frm_en), .evt_sel(evt_sel),
        .stat(stat), .thr(thr)
    );

    rtg_pixdiv #(.DW_DIV(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_m1(div_m1), .tick(tick)
    );

    assign h_adv = tick;
    assign v_adv = tick && h_wrap;

    rtg_seg #(.CW(CW)) u_hseg (
        .clk(clk), .rst_n(rst_n), .clr(!run), .adv(h_adv), .lim(h_lim),
        .state(h_st), .last(h_last), .wrap(h_wrap)
    );

    rtg_seg #(.CW(CW)) u_vseg (
        .clk(clk), .rst_n(rst_n), .clr(!run), .adv(v_adv), .lim(v_lim),
        .state(v_st), .last(v_last), .wrap(v_wrap)
    );

    always_comb begin
        frame_evt = 1'b0;
        if (v_adv && v_last) begin
            frame_evt = evt_sel ? (v_st == SEG_BACK) : (v_st == SEG_FRONT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_no <= '0;
        end else if (!run) begin
            line_no <= '0;
        end else if (v_adv) begin
            line_no <= v_wrap ? '0 : line_no + 1'b1;
        end
    end

    always_comb begin
        de         = run && (h_st == SEG_ACTIVE) && (v_st == SEG_ACTIVE);
        hsync      = (run && (h_st == SEG_SYNC)) ^ hs_inv;
        vsync      = (run && (v_st == SEG_SYNC)) ^ vs_inv;
        frame_irq  = stat && glb_en;
        line_match = run && (line_no == thr);
    end

    assign v_in_sync = (v_st == SEG_SYNC);

    AST_VSYNC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) $rose(v_in_sync) |-> (h_st == SEG_ACTIVE)); // R3
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (v_adv && v_wrap) |=> (line_no == '0)); // R9

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          hsync, vsync, de, frame_irq, line_match;

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 0;

    int m_run, m_hinv, m_vinv, m_div, m_dc, m_hp, m_vp;
    int m_glb, m_frm, m_sel, m_stat, m_thr;
    int mh[4];
    int mv[4];

    always #5 clk = ~clk;

    raster_timing_gen #(.AW(AW), .DW(DW), .CW(CW)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .frame_irq(frame_irq), .line_match(line_match)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int htot();
        return mh[0] + mh[1] + mh[2] + mh[3] + 4;
    endfunction
    function automatic int vtot();
        return mv[0] + mv[1] + mv[2] + mv[3] + 4;
    endfunction
    function automatic bit e_de();
        return m_run != 0 && m_hp <= mh[0] && m_vp <= mv[0];
    endfunction
    function automatic bit e_hs();
        bit s = m_run != 0 && m_hp >= mh[0] + mh[1] + 2 && m_hp <= mh[0] + mh[1] + mh[2] + 2;
        return s ^ (m_hinv != 0);
    endfunction
    function automatic bit e_vs();
        bit s = m_run != 0 && m_vp >= mv[0] + mv[1] + 2 && m_vp <= mv[0] + mv[1] + mv[2] + 2;
        return s ^ (m_vinv != 0);
    endfunction

    // behavioural reference: pixel and line positions counted from frame start
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_hinv = 0; m_vinv = 0; m_div = 0; m_dc = 0; m_hp = 0; m_vp = 0;
            m_glb = 0; m_frm = 0; m_sel = 0; m_stat = 0; m_thr = 0;
            for (int i = 0; i < 4; i++) begin mh[i] = 0; mv[i] = 0; end
        end else begin
            bit ev;
            int d;
            ev = 0;
            d = int'(reg_wdata);
            if (m_run == 0) begin
                m_dc = 0; m_hp = 0; m_vp = 0;
            end else if (m_dc >= m_div) begin
                m_dc = 0;
                if (m_hp == htot() - 1) begin
                    m_hp = 0;
                    m_vp = (m_vp == vtot() - 1) ? 0 : m_vp + 1;
                    ev = (m_sel != 0) ? (m_vp == 0) : (m_vp == mv[0] + mv[1] + 2);
                end else begin
                    m_hp++;
                end
            end else begin
                m_dc++;
            end
            if (reg_wr && reg_addr == 11 && d[0]) m_stat = 0;
            if (ev && m_frm != 0) m_stat = 1;
            if (reg_wr) begin
                case (int'(reg_addr))
                    0: begin
                        if (d[1]) begin
                            m_run = 0; m_stat = 0;
                        end else begin
                            m_run = d & 1; m_hinv = (d >> 2) & 1; m_vinv = (d >> 3) & 1;
                        end
                    end
                    1, 2, 3, 4: mh[int'(reg_addr) - 1] = d & 12'hFFF;
                    5, 6, 7, 8: mv[int'(reg_addr) - 5] = d & 12'hFFF;
                    9:  m_div = (d == 0) ? 0 : ((d > 255) ? 254 : d - 1);
                    10: begin m_glb = d & 1; m_frm = (d >> 1) & 1; m_sel = (d >> 2) & 1; end
                    12: m_thr = d & 12'hFFF;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R5", "de", de, e_de());
            chk("R2", "hsync", hsync, e_hs());
            chk("R3", "vsync", vsync, e_vs());
            chk("R7", "frame_irq", frame_irq, m_stat != 0 && m_glb != 0);
            chk("R9", "line_match", line_match, m_run != 0 && m_vp == m_thr);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    // exp -1: model line index, exp -2: model status
    task automatic rd(input int a, input int exp, input string req);
        int e;
        @(posedge clk); #3;
        reg_addr = AW'(a);
        #1;
        e = (exp == -1) ? m_vp : ((exp == -2) ? m_stat : exp);
        chk(req, $sformatf("read reg %0d", a), 32'(reg_rdata), e);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset de", de, 0);
        chk("R1", "reset hsync", hsync, 0);
        chk("R1", "reset vsync", vsync, 0);
        chk("R1", "reset irq", frame_irq, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd(9, 0, "R1"); rd(10, 0, "R1"); rd(11, 0, "R1"); rd(13, 0, "R1");
        chk_on = 1;

        // R2 R3: small raster, zero-valued porches included
        wr(1, 7); wr(2, 1); wr(3, 2); wr(4, 1);
        wr(5, 3); wr(6, 0); wr(7, 1); wr(8, 0);
        rd(3, 2, "R2"); rd(7, 1, "R3");
        wr(9, 1); wr(10, 3); wr(12, 2);
        wr(0, 1);
        run_cycles(250);
        rd(11, 1, "R6");
        rd(13, -1, "R9");
        wr(11, 1);
        rd(11, -2, "R8");
        run_cycles(60);
        rd(13, -1, "R9");

        // R4 divisor clamp and slower pixel rate
        wr(9, 300); rd(9, 254, "R4");
        wr(9, 0);   rd(9, 0, "R4");
        wr(9, 3);   rd(9, 2, "R4");
        run_cycles(1000);

        // R5 inverted sync polarity
        wr(0, 13);
        run_cycles(400);
        wr(9, 1);

        // R6 event at first active line
        wr(11, 1);
        wr(10, 7);
        run_cycles(300);
        rd(11, 1, "R6");

        // R7 global enable off: status latches, irq low
        wr(10, 6);
        wr(11, 1);
        run_cycles(300);
        rd(11, 1, "R7");
        chk("R7", "irq masked", frame_irq, 0);

        // R9 threshold move
        wr(12, 0);
        run_cycles(200);
        wr(12, 7);
        run_cycles(200);

        // R10 soft reset mid-frame keeps configuration
        run_cycles(37);
        wr(0, 2);
        rd(0, 12, "R10");
        rd(11, 0, "R10");
        rd(1, 7, "R10");
        rd(10, 6, "R10");

        // R11 idle hold
        run_cycles(50);
        rd(13, 0, "R11");
        @(negedge clk);
        chk("R11", "idle de", de, 0);
        chk("R11", "idle hsync", hsync, 1);
        chk("R11", "idle vsync", vsync, 1);
        wr(0, 1);
        run_cycles(300);
        rd(13, -1, "R11");

        chk_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule